// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block holds the 16-bit management registers of a gigabit Ethernet transceiver. A management-frame slave that has already decoded the serial protocol drives it through a flat port: a 5-bit register address, a write strobe with write data, and a read strobe. Read data is combinational from the address. Each address follows its own access rule:
- read-write registers store what is written;
- fixed registers ignore writes;
- write-only and unimplemented addresses read as zero.

Two registers have behaviour of their own.

The basic status register carries a link-status flag that is latched low. A falling live link clears it at once. A rising link only shows up after a status read, because each status read returns the latched value and then reloads the flag from the live link. The control register's reset bit is not stored. Writing a 1 to it emits a one-cycle soft-reset request and leaves every register unchanged.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the registers read back as follows:
  - address 0 (control) reads 0x1140;
  - address 1 (status) reads 0x7969, with link flag bit 2 at 0;
  - address 2 reads 0x0141;
  - address 3 reads the EXT_ID parameter (default 0x0C20);
  - address 4 (advertisement) reads 0x01E1;
  - address 5 (partner ability) reads 0x01E0;
  - address 9 reads 0x1E00;
  - address 16 (transceiver control) reads 0x0068;
  - address 17 reads 0x0000.
- R2: A write to address 0 with bit 15 clear, or any write to address 4 or 16, stores the full 16-bit value. The value reads back from the cycle after the write edge.
- R3: Writes to addresses 1, 2, 3, 5, 9, 10 and 17 are discarded. Their read values are unchanged afterwards.
- R4: All other addresses read 0 and ignore writes. This covers 6, 7, 8, 15, 18 to 21, 26, 29 and 30 as well as undefined addresses such as 11 and 31.
- R5: A write to address 0 with bit 15 set does not change the control register. It raises softResetReq high for exactly the one cycle after the write edge.
- R6: A status read returns the flag as it was latched before the read edge. At that edge the flag is reloaded from linkUp.
- R7: While linkUp is 0, the status link flag (bit 2 of address 1) is 0 from the next clock edge onward.
- R8: A rising linkUp does not set the status link flag. The first status read after the rise still returns 0 in bit 2, and the following read returns 1.
- R9: Bit 10 of address 17 follows linkUp, delayed by one clock edge.
- R10: Address 10 always reads 0x3C00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe; a status read triggers the reload |
| rdData | output | 16 | Read data for regAddr (combinational) |
| linkUp | input | 1 | Live link state |
| softResetReq | output | 1 | One-cycle soft-reset request |

## Verification
The access policies are tried with two patterns, all-ones and a mixed word, written to every class of address:
- Read-write registers echo the data.
- Fixed registers keep their reset values.
- Dead addresses return zero, which separates a discarded write from a mis-decoded store.

The link flag is driven through two orders:
- a rise followed by two reads, which separates the latched value from the reloaded one;
- a fall with no read, which shows the immediate clear.

A control write with bit 15 set, placed next to an ordinary control write, shows that the reset bit intercepts the store and that the request pulse lasts one cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [REG_W-1:0]  word_t;

  localparam addr_t A_CTRL   = 5'd0;
  localparam addr_t A_STAT   = 5'd1;
  localparam addr_t A_ID     = 5'd2;
  localparam addr_t A_EXTID  = 5'd3;
  localparam addr_t A_ADV    = 5'd4;
  localparam addr_t A_PART   = 5'd5;
  localparam addr_t A_GCTL   = 5'd9;
  localparam addr_t A_GSTAT  = 5'd10;
  localparam addr_t A_SPCTL  = 5'd16;
  localparam addr_t A_SPSTAT = 5'd17;

  localparam word_t RST_CTRL  = 16'h1140;
  localparam word_t RST_ADV   = 16'h01E1;
  localparam word_t RST_SPCTL = 16'h0068;
  localparam word_t STAT_BASE = 16'h7969;
  localparam word_t ID_VAL    = 16'h0141;
  localparam word_t PART_VAL  = 16'h01E0;
  localparam word_t GCTL_VAL  = 16'h1E00;
  localparam word_t GSTAT_VAL = 16'h3C00;

  localparam int CTRL_RST_BIT    = 15;
  localparam int STAT_LINK_BIT   = 2;
  localparam int SPSTAT_LINK_BIT = 10;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic ldCtrl;
    logic ldAdv;
    logic ldSpCtl;
    logic statRead;
    logic softRst;
  } strobe_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  addr_t   regAddr,
  input  logic    wrEn,
  input  logic    rdEn,
  input  logic    rstBit,
  output strobe_t stb,
  output logic    softResetReq
);
  always_comb begin
    stb          = '0;
    stb.statRead = rdEn && (regAddr == A_STAT);
    if (wrEn) begin
      unique case (regAddr)
        A_CTRL: begin
          stb.ldCtrl  = !rstBit;
          stb.softRst = rstBit;
        end
        A_ADV:   stb.ldAdv   = 1'b1;
        A_SPCTL: stb.ldSpCtl = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) softResetReq <= 1'b0;
    else        softResetReq <= stb.softRst;
  end
endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter word_t EXT_ID = 16'h0C20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t stb,
  input  addr_t   regAddr,
  input  word_t   wrData,
  input  logic    linkUp,
  output word_t   rdData,
  output word_t   ctrlQ,
  output logic    lsBitQ
);
  word_t advQ, spCtlQ;
  logic  spLinkQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ   <= RST_CTRL;
      advQ    <= RST_ADV;
      spCtlQ  <= RST_SPCTL;
      lsBitQ  <= 1'b0;
      spLinkQ <= 1'b0;
    end else begin
      if (stb.ldCtrl)  ctrlQ  <= wrData;
      if (stb.ldAdv)   advQ   <= wrData;
      if (stb.ldSpCtl) spCtlQ <= wrData;
      spLinkQ <= linkUp;
      if (!linkUp)          lsBitQ <= 1'b0;
      else if (stb.statRead) lsBitQ <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      A_CTRL:   rdData = ctrlQ;
      A_STAT: begin
        rdData = STAT_BASE;
        rdData[STAT_LINK_BIT] = lsBitQ;
      end
      A_ID:     rdData = ID_VAL;
      A_EXTID:  rdData = EXT_ID;
      A_ADV:    rdData = advQ;
      A_PART:   rdData = PART_VAL;
      A_GCTL:   rdData = GCTL_VAL;
      A_GSTAT:  rdData = GSTAT_VAL;
      A_SPCTL:  rdData = spCtlQ;
      A_SPSTAT: rdData[SPSTAT_LINK_BIT] = spLinkQ;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] EXT_ID = 16'h0C20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  regAddr,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic        linkUp,
  output logic        softResetReq
);
  strobe_t stb;
  word_t   ctrlQ;
  logic    lsBitQ;

  phy_mgmt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .rstBit(wrData[CTRL_RST_BIT]), .stb(stb), .softResetReq(softResetReq)
  );

  phy_mgmt_dp #(.EXT_ID(EXT_ID)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .regAddr(regAddr), .wrData(wrData),
    .linkUp(linkUp), .rdData(rdData), .ctrlQ(ctrlQ), .lsBitQ(lsBitQ)
  );
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  regAddr,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        rdEn,
  input logic [15:0] rdData,
  input logic        linkUp,
  input logic        softResetReq,
  input logic [15:0] ctrlQ,
  input logic        lsBitQ
);
  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrEn && regAddr == 5'd0 && !wrData[15]) |-> ctrlQ == $past(wrData));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrEn && regAddr == 5'd0 && wrData[15]) |-> ctrlQ == $past(ctrlQ));
  // R5
  softrst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softResetReq |-> $past(wrEn && regAddr == 5'd0 && wrData[15]));
  // R7
  link_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !linkUp |=> !lsBitQ);
  // R8
  link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsBitQ) |-> $past(rdEn && regAddr == 5'd1 && linkUp));
  // R4
  dead_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == 5'd31 || regAddr == 5'd6) |-> rdData == 16'h0000);
endmodule

bind phy_mgmt_regs phy_mgmt_chk u_chk (.*);

// File: tb/phy_mgmt_regs_bench.sv
`timescale 1ns/1ps
module phy_mgmt_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        linkUp = 1'b0;
  logic        softResetReq;
  int nChecks = 0;
  int nFails  = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  phy_mgmt_regs u_phy_mgmt_regs (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Read one register: rdData sampled before the edge that commits the read.
  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v);  chk("R1 ctrl", v, 16'h1140);
    rd(1, v);  chk("R1 status", v, 16'h7969);
    rd(2, v);  chk("R1 id", v, 16'h0141);
    rd(3, v);  chk("R1 extid", v, 16'h0C20);
    rd(4, v);  chk("R1 adv", v, 16'h01E1);
    rd(5, v);  chk("R1 partner", v, 16'h01E0);
    rd(9, v);  chk("R1 gctl", v, 16'h1E00);
    rd(16, v); chk("R1 spctl", v, 16'h0068);
    rd(17, v); chk("R1 spstat", v, 16'h0000);
    chk("R1 softResetReq", {15'd0, softResetReq}, 16'd0);
  endtask

  task automatic t_rw();
    logic [15:0] v;
    foreach (wrPat[i]) begin
      wr(0, wrPat[i] & 16'h7FFF); rd(0, v);  chk("R2 ctrl", v, wrPat[i] & 16'h7FFF);
      wr(4, wrPat[i]);            rd(4, v);  chk("R2 adv", v, wrPat[i]);
      wr(16, wrPat[i]);           rd(16, v); chk("R2 spctl", v, wrPat[i]);
    end
  endtask

  logic [15:0] wrPat [2] = '{16'hFFFF, 16'h5A3C};

  task automatic t_readonly();
    logic [15:0] v;
    wr(1, 16'hFFFF); wr(2, 16'hFFFF); wr(3, 16'hFFFF); wr(5, 16'hFFFF);
    wr(9, 16'hFFFF); wr(10, 16'hFFFF); wr(17, 16'hFFFF);
    rd(1, v);  chk("R3 status", v, 16'h7969);
    rd(2, v);  chk("R3 id", v, 16'h0141);
    rd(3, v);  chk("R3 extid", v, 16'h0C20);
    rd(5, v);  chk("R3 partner", v, 16'h01E0);
    rd(9, v);  chk("R3 gctl", v, 16'h1E00);
    rd(10, v); chk("R10 gstat", v, 16'h3C00);
    rd(17, v); chk("R3 spstat", v, 16'h0000);
  endtask

  logic [4:0] deadList [13] = '{6, 7, 8, 11, 15, 18, 19, 20, 21, 26, 29, 30, 31};

  task automatic t_unimpl();
    logic [15:0] v;
    foreach (deadList[i]) begin
      wr(deadList[i], 16'hA5F0);
      rd(deadList[i], v);
      chk("R4 dead address", v, 16'h0000);
    end
  endtask

  task automatic t_softreset();
    logic [15:0] v;
    wr(0, 16'h1234);
    @(negedge clk);
    regAddr = 0; wrData = 16'h8000; wrEn = 1'b1;
    @(posedge clk); #1
    chk("R5 pulse high", {15'd0, softResetReq}, 16'd1);
    @(negedge clk); wrEn = 1'b0;
    @(posedge clk); #1
    chk("R5 pulse low", {15'd0, softResetReq}, 16'd0);
    rd(0, v); chk("R5 ctrl kept", v, 16'h1234);
  endtask

  task automatic t_link();
    logic [15:0] v;
    @(negedge clk); linkUp = 1'b1;
    repeat (3) @(negedge clk);
    rd(17, v); chk("R9 mirror up", v, 16'h0400);
    rd(1, v);  chk("R8 first read after rise", v, 16'h7969);
    rd(1, v);  chk("R6 reloaded", v, 16'h796D);
    rd(1, v);  chk("R6 stays", v, 16'h796D);
    @(negedge clk); linkUp = 1'b0;
    @(negedge clk);
    regAddr = 1; #1 chk("R7 cleared without read", rdData, 16'h7969);
    rd(17, v); chk("R9 mirror down", v, 16'h0000);
    @(negedge clk); linkUp = 1'b1;
    repeat (2) @(negedge clk);
    rd(1, v);  chk("R8 no self set", v, 16'h7969);
    rd(1, v);  chk("R6 set after read", v, 16'h796D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_readonly();
    t_unimpl();
    t_softreset();
    t_link();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule